// File: doc/BRIEF.md
# Presettable Up/Down Counter Stage

A synchronous binary counter stage, four bits wide by default, that steps up or down on single-cycle request strobes. An active-low load copies a parallel word into the count. A master reset clears the count and overrides everything else. Two active-low terminal-count strobes mark the wrap points. A higher stage can take these strobes directly as its own up and down requests, so several stages chain into a wider counter.

With the divider enable set, the stage works as a programmable divider. A down request that arrives while the count is one reloads the parallel word instead of stepping to zero. The down strobe fires on that reload, so it pulses once for every N down requests, where N is the parallel word (valid for 1 to N_max = 2^W-1).

Top module: `updn_stage`

## Requirements
- R1: With `up_req`=1, `dn_req`=0, `load_n`=1 and `rst`=0, the count increases by one at the clock edge, and all-ones wraps to zero.
- R2: With `dn_req`=1, `up_req`=0, `load_n`=1, `rst`=0 and no divider reload, the count decreases by one at the clock edge, and zero wraps to all-ones.
- R3: If both requests are high, or both are low, and neither load nor reset is active, the count keeps its value.
- R4: While `load_n`=0 (active low) and `rst`=0, the clock edge copies `din` into the count, whatever the requests are.
- R5: `rst`=1 (active high, synchronous) clears the count to zero at the clock edge, and it takes priority over load and counting.
- R6: `tc_up_n` is 0 in exactly those cycles where the count is all-ones and only `up_req` is high. Otherwise it is 1.
- R7: With `div_en`=0, `tc_dn_n` is 0 in exactly those cycles where the count is zero and only `dn_req` is high. Otherwise it is 1.
- R8: With `div_en`=1, a down-only request at count one loads `din`. From a loaded preset of 5, successive down requests give 4,3,2,1,5,4, and the count is never 0.
- R9: With `div_en`=1, `tc_dn_n` is 0 exactly when the count is one and only `dn_req` is high. It is not 0 at count zero.
- R10: Two stages form an 8-bit up/down counter. The high stage takes the low stage's inverted `tc_up_n`/`tc_dn_n` as its requests, and the two stages share clock, reset and load, with the low stage holding the low nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous master reset, active high |
| up_req | input | 1 | Single-cycle count-up request |
| dn_req | input | 1 | Single-cycle count-down request |
| load_n | input | 1 | Parallel load, active low |
| din | input | W | Parallel load data / divide ratio |
| div_en | input | 1 | Divider mode: down terminal count reloads `din` |
| count | output | W | Current count |
| tc_up_n | output | 1 | Up terminal count, active low |
| tc_dn_n | output | 1 | Down terminal count (or divider reload), active low |

## Verification
On every cycle, the embedded properties check the following:
- the reset and load priority;
- single steps up and down;
- holding when the requests collide;
- the count that follows each terminal strobe;
- the reload in divider mode;
- that the two strobes are never active together.

Some behaviour only the bench scenarios can show:
- the full divide-by-five sequence;
- that a divider never passes through zero;
- that an 8-bit chain of two stages counts correctly across nibble carries and borrows.

Random mixes of requests, loads and resets are compared against a bench model of the count and of both strobes.

// File: rtl/updn_stage.sv
module updn_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_req,
  input  logic         dn_req,
  input  logic         load_n,
  input  logic [W-1:0] din,
  input  logic         div_en,
  output logic [W-1:0] count,
  output logic         tc_up_n,
  output logic         tc_dn_n
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic up_only, dn_only, at_top, at_one, at_zero, reload;

  assign up_only = up_req & ~dn_req;
  assign dn_only = dn_req & ~up_req;
  assign at_top  = (count == ALL1);
  assign at_one  = (count == ONE);
  assign at_zero = (count == ZERO);
  assign reload  = div_en & dn_only & at_one;

  assign tc_up_n = ~(up_only & at_top);
  assign tc_dn_n = ~(dn_only & (div_en ? at_one : at_zero));

  always_ff @(posedge clk) begin
    if (rst)                  count <= ZERO;
    else if (!load_n || reload) count <= din;
    else if (up_only)         count <= count + ONE;
    else if (dn_only)         count <= count - ONE;
  end

  a_r5_reset_clears: assert property (@(posedge clk) rst |=> count == ZERO);

  a_r4_load_copies: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> count == $past(din));

  a_r1_step_up: assert property (@(posedge clk) disable iff (rst)
    (load_n && up_req && !dn_req) |=> count == W'($past(count) + ONE));

  a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
    (load_n && dn_req && !up_req && !(div_en && count == ONE)) |=> count == W'($past(count) - ONE));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (load_n && (up_req == dn_req)) |=> $stable(count));

  a_r6_up_wrap: assert property (@(posedge clk) disable iff (rst)
    (!tc_up_n && load_n) |=> count == ZERO);

  a_r7_down_wrap: assert property (@(posedge clk) disable iff (rst)
    (!tc_dn_n && !div_en && load_n) |=> count == ALL1);

  a_r8_div_reload: assert property (@(posedge clk) disable iff (rst)
    (!tc_dn_n && div_en) |=> count == $past(din));

  a_r9_tc_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~tc_up_n, ~tc_dn_n}));
endmodule

// File: tb/updn_stage_test.sv
module updn_stage_test;
  localparam int W = 4;
  localparam int CLK_P = 10;

  logic clk = 0;
  logic rst, up_req, dn_req, load_n, div_en;
  logic [W-1:0] din, count;
  logic tc_up_n, tc_dn_n;

  logic c_up, c_dn, c_ld_n;
  logic [7:0] c_din;
  logic [3:0] lo_q, hi_q;
  logic lo_tcu, lo_tcd, hi_tcu, hi_tcd;

  int total = 0, bad = 0;
  bit done = 0;
  logic [W-1:0] exp_q;
  logic [7:0] exp_c;

  always #(CLK_P/2) clk = ~clk;

  updn_stage #(.W(W)) uut (.clk(clk), .rst(rst), .up_req(up_req), .dn_req(dn_req),
    .load_n(load_n), .din(din), .div_en(div_en), .count(count),
    .tc_up_n(tc_up_n), .tc_dn_n(tc_dn_n));

  updn_stage #(.W(4)) cas_lo (.clk(clk), .rst(rst), .up_req(c_up), .dn_req(c_dn),
    .load_n(c_ld_n), .din(c_din[3:0]), .div_en(1'b0), .count(lo_q),
    .tc_up_n(lo_tcu), .tc_dn_n(lo_tcd));

  updn_stage #(.W(4)) cas_hi (.clk(clk), .rst(rst), .up_req(~lo_tcu), .dn_req(~lo_tcd),
    .load_n(c_ld_n), .din(c_din[7:4]), .div_en(1'b0), .count(hi_q),
    .tc_up_n(hi_tcu), .tc_dn_n(hi_tcd));

  function automatic logic [W-1:0] nxt(logic [W-1:0] q, logic r, logic u, logic d,
                                      logic ln, logic [W-1:0] p, logic dv);
    if (r) return '0;
    if (!ln) return p;
    if (u && !d) return q + 1'b1;
    if (d && !u) return (dv && q == 1) ? p : q - 1'b1;
    return q;
  endfunction

  function automatic logic [7:0] nxt8(logic [7:0] q, logic r, logic u, logic d,
                                      logic ln, logic [7:0] p);
    if (r) return '0;
    if (!ln) return p;
    if (u && !d) return q + 8'd1;
    if (d && !u) return q - 8'd1;
    return q;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(string tag, logic r, logic u, logic d, logic ln,
                      logic [W-1:0] p, logic dv);
    logic e_tu, e_td;
    rst = r; up_req = u; dn_req = d; load_n = ln; din = p; div_en = dv;
    #(CLK_P/4);
    e_tu = !(u && !d && exp_q == {W{1'b1}});
    e_td = !(d && !u && (dv ? exp_q == 1 : exp_q == 0));
    chk("R6 tc_up_n", tc_up_n, e_tu);
    chk(dv ? "R9 tc_dn_n" : "R7 tc_dn_n", tc_dn_n, e_td);
    @(posedge clk);
    exp_q = nxt(exp_q, r, u, d, ln, p, dv);
    exp_c = nxt8(exp_c, r, c_up, c_dn, c_ld_n, c_din);
    @(negedge clk);
    chk(tag, count, exp_q);
    chk("R10 cascade", {hi_q, lo_q}, exp_c);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; up_req = 0; dn_req = 0; load_n = 1; din = 0; div_en = 0;
    c_up = 0; c_dn = 0; c_ld_n = 1; c_din = 0;
    exp_q = 'x; exp_c = 'x;
    @(negedge clk);
    step("R5 reset", 1, 0, 0, 1, 0, 0);
    step("R5 reset beats load", 1, 1, 0, 0, 4'd9, 0);
    step("R4 load", 0, 0, 0, 0, 4'd14, 0);
    step("R4 load over up", 0, 1, 0, 0, 4'd15, 0);
    step("R1 wrap up", 0, 1, 0, 1, 0, 0);
    step("R3 both", 0, 1, 1, 1, 0, 0);
    step("R2 wrap down", 0, 0, 1, 1, 0, 0);
    step("R3 idle", 0, 0, 0, 1, 0, 0);
    step("R2 down", 0, 0, 1, 1, 0, 0);
    step("R4 preset 5", 0, 0, 0, 0, 4'd5, 1);
    for (int i = 0; i < 6; i++) step("R8 divide by 5", 0, 0, 1, 1, 4'd5, 1);
    chk("R8 sequence end", count, 4'd4);
    step("R4 load 0", 0, 0, 0, 0, 4'd0, 1);
    step("R9 zero in divider", 0, 0, 1, 1, 4'd3, 1);
    // R10 cascade: load 0x0F then up across nibble carry, then borrow back
    c_din = 8'h0F; c_ld_n = 0;
    step("R4 cascade load", 0, 0, 0, 1, 0, 0);
    c_ld_n = 1; c_up = 1;
    step("R10 carry", 0, 0, 0, 1, 0, 0);
    c_up = 0; c_dn = 1;
    step("R10 borrow", 0, 0, 0, 1, 0, 0);
    step("R10 borrow2", 0, 0, 0, 1, 0, 0);
    c_dn = 0;
    for (int i = 0; i < 3000; i++) begin
      logic r, u, d, ln, dv;
      logic [W-1:0] p;
      r  = ($urandom % 60) == 0;
      ln = ($urandom % 10) != 0;
      u  = ($urandom % 3) == 0;
      d  = ($urandom % 3) == 0;
      dv = (i / 500) % 2;
      p  = W'($urandom);
      c_up = ($urandom % 2) == 0;
      c_dn = ($urandom % 4) == 0;
      c_ld_n = ($urandom % 50) != 0;
      c_din = 8'($urandom);
      step(dv ? "R8 random" : "R1 random", r, u, d, ln, p, dv);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule